// File: doc/BRIEF.md
# Dual-Input Edge Timestamp Capture Unit

This unit timestamps transitions on two external input pins. A 16-bit counter runs freely, stepping once per clock. When either pin rises or falls, an 8-bit slice of that counter is latched into a capture register reserved for that pin and that direction. There are four capture registers in all. A 3-bit prescale field picks which slice is latched, so firmware trades resolution for range. Each capture also raises its own flag in a status register. The OR of the flags, gated by a per-flag enable, drives one interrupt request.

In wide mode, channel 0 is measured with full 16-bit resolution. The pin-1 capture registers then hold the upper byte of each pin-0 timestamp, and pin 1 is ignored. Firmware uses a byte-wide register port to read the captures and flags, to set the configuration and enables, and to clear a flag by writing 1 to it.

Register map (3-bit address): 0 = configuration (bits 2:0 prescale, bit 3 wide mode), 1 = pin-0 rise capture, 2 = pin-0 fall capture, 3 = pin-1 rise capture, 4 = pin-1 fall capture, 5 = status, 6 = interrupt enable (bits 3:0), 7 = reads 0.

Top module: `edge_stamp_unit`

## Requirements
- R1: After reset, every register (configuration, the four captures, status, enable) reads 0 and `irq_o` is 0.
- R2: Each pin has a two-flop synchronizer. Take a new pin level first sampled at rising clock edge n, where n counts edges since reset release. The capture uses the counter value n+1, and the result is readable after edge n+2.
- R3: A rising edge on pin 0 writes address 1 and sets status bit 0. A falling edge on pin 0 writes address 2 and sets bit 1. A rising edge on pin 1 writes address 3 and sets bit 2. A falling edge on pin 1 writes address 4 and sets bit 3.
- R4: With prescale p (configuration bits 2:0) and wide mode off, the captured byte is counter bits [p+7:p]. Configuration bits 3:0 read back as written, and bits 7:4 read 0.
- R5: In wide mode (configuration bit 3), a pin-0 rising edge stores counter bits [7:0] at address 1 and bits [15:8] at address 3. A pin-0 falling edge stores them at addresses 2 and 4. Prescale is ignored. Pin-1 edges change no capture register and no status bit.
- R6: Writing 1 to status bit k (k = 0..3) clears it. Writing 0 has no effect. Status bits 7:4 read 0, and writes to them are ignored.
- R7: If a write-1-to-clear and a new event on the same status bit fall in the same clock cycle, the bit stays set.
- R8: `irq_o` is high exactly when some status bit k is set with enable bit k (address 6) set. The enable register reads back bits 3:0.
- R9: Each edge gives one capture. While a pin holds its level, its capture registers keep their value, and a cleared flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 2 | Asynchronous input pins to timestamp |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Write strobe, taken at the rising clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
A pin change lands in the registers three rising edges after it is driven. The bench drives pins and the bus on falling clock edges and waits four falling edges before it reads. It counts rising edges since reset release and predicts each timestamp as the drive cycle plus two. Reads are combinational and are sampled 1 ns after the address is set. Writes take effect at the next rising edge. The same-cycle test therefore places the clear strobe on the exact edge that the capture completes.

// File: rtl/esu_pkg.sv
package esu_pkg;
  localparam int CNT_W   = 16;
  localparam int CAP_W   = 8;
  localparam int PRE_W   = 3;
  localparam int NPIN    = 2;
  localparam int NEV     = 2 * NPIN;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 8;

  localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CAP0 = 3'd1;
  localparam logic [ADDR_W-1:0] A_STS  = 3'd5;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd6;

  typedef logic [NEV-1:0][CAP_W-1:0] cap_arr_t;
endpackage

// File: rtl/esu_edge_sync.sv
module esu_edge_sync #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~prev_q;
  assign fall_o = ~s2_q & prev_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    p_one_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[i] |=> !rise_o[i]);
    p_one_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_o[i] |=> !fall_o[i]);
  end
endmodule

// File: rtl/esu_capture.sv
module esu_capture
  import esu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NEV-1:0]   ev_i,
  input  logic             wide_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [CNT_W-1:0] cnt_i,
  output cap_arr_t         cap_o
);
  cap_arr_t cap_q;
  logic [CAP_W-1:0] win, lo, hi;

  assign win = CAP_W'(cnt_i >> pre_i);
  assign lo  = cnt_i[CAP_W-1:0];
  assign hi  = cnt_i[2*CAP_W-1:CAP_W];

  for (genvar i = 0; i < NEV; i++) begin : g_cap
    if (i < 2) begin : g_ch0
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       cap_q[i] <= '0;
        else if (ev_i[i])  cap_q[i] <= wide_i ? lo : win;
      end
    end else begin : g_ch1
      // wide mode: channel-1 slots hold the upper byte of channel 0
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     cap_q[i] <= '0;
        else if (wide_i && ev_i[i-2])    cap_q[i] <= hi;
        else if (!wide_i && ev_i[i])     cap_q[i] <= win;
      end
    end
  end

  assign cap_o = cap_q;

  p_hold_no_event_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == '0) |=> $stable(cap_q));
  p_wide_upper_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_i && ev_i[0]) |=> cap_q[2] == $past(cnt_i[2*CAP_W-1:CAP_W]));
endmodule

// File: rtl/esu_status.sv
module esu_status
  import esu_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NEV-1:0] ev_i,
  input  logic           clr_i,
  input  logic [NEV-1:0] clr_mask_i,
  input  logic           ien_we_i,
  input  logic [NEV-1:0] ien_i,
  output logic [NEV-1:0] sts_o,
  output logic [NEV-1:0] ien_o,
  output logic           irq_o
);
  logic [NEV-1:0] sts_q, ien_q, clr;

  assign clr = clr_i ? clr_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      ien_q <= '0;
    end else begin
      sts_q <= (sts_q & ~clr) | ev_i;  // new event wins over clear
      if (ien_we_i) ien_q <= ien_i;
    end
  end

  assign sts_o = sts_q;
  assign ien_o = ien_q;
  assign irq_o = |(sts_q & ien_q);

  p_event_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i != '0) |=> ((sts_q & $past(ev_i)) == $past(ev_i)));
  p_w1c_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((sts_q & $past(clr_mask_i & ~ev_i)) == '0));
  p_irq_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q == '0) |-> !irq_o);
endmodule

// File: rtl/edge_stamp_unit.sv
module edge_stamp_unit
  import esu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPIN-1:0]   pin_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int CFG_W = PRE_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CFG_W-1:0] cfg_q;
  logic [NPIN-1:0]  rise, fall;
  logic [NEV-1:0]   ev, ev_eff, sts, ien;
  logic             wide;
  cap_arr_t         cap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cfg_q <= '0;
    else if (wr_i && addr_i == A_CFG)   cfg_q <= wdata_i[CFG_W-1:0];
  end

  assign wide = cfg_q[PRE_W];

  esu_edge_sync #(.N(NPIN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .rise_o(rise),
    .fall_o(fall)
  );

  assign ev     = {fall[1], rise[1], fall[0], rise[0]};
  assign ev_eff = wide ? {2'b00, ev[1:0]} : ev;

  esu_capture u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ev_i  (ev_eff),
    .wide_i(wide),
    .pre_i (cfg_q[PRE_W-1:0]),
    .cnt_i (cnt_q),
    .cap_o (cap)
  );

  esu_status u_sts (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (ev_eff),
    .clr_i     (wr_i && addr_i == A_STS),
    .clr_mask_i(wdata_i[NEV-1:0]),
    .ien_we_i  (wr_i && addr_i == A_IEN),
    .ien_i     (wdata_i[NEV-1:0]),
    .sts_o     (sts),
    .ien_o     (ien),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CFG)                                    rdata_o = DATA_W'(cfg_q);
    else if (addr_i >= A_CAP0 && addr_i < A_CAP0 + NEV)     rdata_o = cap[addr_i - A_CAP0];
    else if (addr_i == A_STS)                               rdata_o = DATA_W'(sts);
    else if (addr_i == A_IEN)                               rdata_o = DATA_W'(ien);
  end

  p_wide_pin1_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide && !(wr_i && addr_i == A_STS)) |=> $stable(sts[3:2]));
endmodule

// File: tb/edge_stamp_unit_tb_top.sv
`timescale 1ns/1ps
module edge_stamp_unit_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] pins = '0;
  logic [2:0] addr = '0;
  logic       we = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  int         cyc = 0;
  int         checks = 0;
  int         errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  edge_stamp_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .addr_i(addr),
    .wr_i(we), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1;
    @(negedge clk);
    we = 0;
  endtask

  // drive a pin, return the expected raw counter stamp
  task automatic pin_edge(input int idx, input logic lvl, output int stamp);
    @(negedge clk);
    pins[idx] = lvl;
    stamp = (cyc + 2) & 16'hffff;
    repeat (4) @(negedge clk);
  endtask

  function automatic int win(input int s, input int p);
    return (s >> p) & 8'hff;
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1 register reset", d, 0);
    end
    chk("R1 irq reset", irq, 0);
  endtask

  task automatic t_basic_edges();
    logic [7:0] d;
    int s;
    pin_edge(0, 1, s); rd(3'd1, d); chk("R2 pin0 rise stamp", d, win(s, 0));
    rd(3'd5, d); chk("R3 status bit0", d, 8'h01);
    pin_edge(0, 0, s); rd(3'd2, d); chk("R3 pin0 fall stamp", d, win(s, 0));
    pin_edge(1, 1, s); rd(3'd3, d); chk("R3 pin1 rise stamp", d, win(s, 0));
    pin_edge(1, 0, s); rd(3'd4, d); chk("R3 pin1 fall stamp", d, win(s, 0));
    rd(3'd5, d); chk("R3 status all", d, 8'h0f);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    wr(3'd5, 8'h00); rd(3'd5, d); chk("R6 write zero no effect", d, 8'h0f);
    wr(3'd5, 8'hf0); rd(3'd5, d); chk("R6 reserved write ignored", d, 8'h0f);
    wr(3'd5, 8'h05); rd(3'd5, d); chk("R6 clear bits 0 and 2", d, 8'h0a);
    wr(3'd5, 8'h0a); rd(3'd5, d); chk("R6 clear rest", d, 8'h00);
  endtask

  task automatic t_prescale();
    logic [7:0] d;
    int s;
    wr(3'd0, 8'hf3); rd(3'd0, d); chk("R4 config readback", d, 8'h03);
    pin_edge(0, 1, s); rd(3'd1, d); chk("R4 prescale 3", d, win(s, 3));
    wr(3'd0, 8'h07);
    pin_edge(0, 0, s); rd(3'd2, d); chk("R4 prescale 7", d, win(s, 7));
    wr(3'd0, 8'h02);
    pin_edge(1, 1, s); rd(3'd3, d); chk("R4 prescale 2 pin1", d, win(s, 2));
    pin_edge(1, 0, s);
    wr(3'd0, 8'h00);
    wr(3'd5, 8'h0f);
  endtask

  task automatic t_hold();
    logic [7:0] d, c;
    rd(3'd3, c);
    repeat (12) @(negedge clk);
    rd(3'd5, d); chk("R9 flags stay clear while held", d, 8'h00);
    rd(3'd3, d); chk("R9 capture held", d, c);
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    int s;
    @(negedge clk);
    pins[0] = 1;
    s = cyc + 2;
    @(negedge clk);
    @(negedge clk);
    addr = 3'd5; wdata = 8'h01; we = 1;  // strobe on the capture edge
    @(negedge clk);
    we = 0;
    repeat (2) @(negedge clk);
    rd(3'd5, d); chk("R7 event wins over clear", d, 8'h01);
    rd(3'd1, d); chk("R7 capture taken", d, win(s, 0));
    wr(3'd5, 8'h01); rd(3'd5, d); chk("R7 later clear works", d, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    int s;
    pin_edge(0, 0, s);  // sets bit1
    chk("R8 irq masked", irq, 0);
    wr(3'd6, 8'hf4); rd(3'd6, d); chk("R8 enable readback", d, 8'h04);
    chk("R8 other bit enabled only", irq, 0);
    wr(3'd6, 8'h02); rd(3'd6, d);
    chk("R8 irq asserted", irq, 1);
    wr(3'd5, 8'h02); rd(3'd5, d);
    chk("R8 irq drops on clear", irq, 0);
    wr(3'd6, 8'h00);
  endtask

  task automatic t_wide();
    logic [7:0] d, c3, c4;
    int s;
    repeat (300) @(negedge clk);  // nonzero upper byte
    wr(3'd0, 8'h0d);               // wide, prescale 5 ignored
    pin_edge(0, 1, s);
    rd(3'd1, d); chk("R5 wide low byte rise", d, s & 8'hff);
    rd(3'd3, d); chk("R5 wide high byte rise", d, (s >> 8) & 8'hff);
    pin_edge(0, 0, s);
    rd(3'd2, d); chk("R5 wide low byte fall", d, s & 8'hff);
    rd(3'd4, d); chk("R5 wide high byte fall", d, (s >> 8) & 8'hff);
    wr(3'd5, 8'h0f);
    rd(3'd3, c3); rd(3'd4, c4);
    pin_edge(1, 1, s);
    pin_edge(1, 0, s);
    rd(3'd5, d); chk("R5 pin1 no status in wide", d, 8'h00);
    rd(3'd3, d); chk("R5 pin1 no capture rise", d, c3);
    rd(3'd4, d); chk("R5 pin1 no capture fall", d, c4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    fork
      begin
        t_reset();
        t_basic_edges();
        t_w1c();
        t_prescale();
        t_hold();
        t_same_cycle();
        t_irq();
        t_wide();
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule